// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single byte requests into the pin-level strobe pattern of an 8-bit asynchronous NAND flash bus. A request is one of four kinds: command byte, address byte, data write or data read. Requests enter through a valid/ready port, one at a time. The block drives chip enable, the two latch enables, the active-low write and read strobes and the data bus with its output enable. For a read it returns the captured byte with a one-cycle valid pulse.

The block runs on a clock at twice the system rate, so each clock cycle ("tick") is half a system period. Setup, hold and recovery spans are fixed tick counts. Two 4-bit delay inputs stretch the low phase of the write and read strobes, and both are sampled when a request is accepted.

States and transitions:

- IDLE: ready is high. An accepted request moves to SETUP.
- SETUP: chip enable is active. Writes spend 5 ticks here and reads spend 2. Then the block moves to STROBE.
- STROBE: the write or read strobe is low for 2×(delay+1) ticks. Then the block moves to HOLD.
- HOLD: chip enable stays active for 6 ticks. After a read the block returns to IDLE. After any write kind it moves to GAP.
- GAP: one tick with every pin idle and ready still low. Then the block moves to IDLE.

Top module: `nfs_sequencer`

## Requirements
- R1: The request kind code is 0 for command, 1 for address, 2 for data write and 3 for data read. A command request raises command latch enable only, an address request raises address latch enable only, and data requests raise neither. The two latch enables are never high together.
- R2: On a write kind, the write strobe is low for exactly 2×(wr_dly+1) consecutive ticks.
- R3: On a read, the read strobe is low for exactly 2×(rd_dly+1) consecutive ticks.
- R4: Chip enable goes low in the tick after acceptance. This is 5 ticks before the write strobe falls, or 2 ticks before the read strobe falls. Chip enable stays low for 6 ticks after the strobe rises.
- R5: On command and address requests, the latch enable is high from the tick after acceptance (5 ticks before the write strobe falls) until 5 ticks after the write strobe rises.
- R6: For write kinds, the bus output enable is high and the bus carries the request byte over the same span as R5. During reads and idle time the output enable is low.
- R7: At least 10 ticks pass from a write strobe rising to the next read strobe falling.
- R8: For a read, the bus is sampled at the clock edge that ends the strobe low phase. The response valid is high for exactly one tick, in the tick right after that edge, together with the sampled byte.
- R9: The delay inputs, kind and data are sampled at acceptance. Changing them later has no effect on the request in progress.
- R10: Ready is high only in IDLE. After a write kind, ready returns 7 ticks after the strobe rises. After a read, ready returns 6 ticks after the strobe rises.
- R11: During and right after reset, chip enable and both strobes are high, both latch enables, the output enable and the response valid are low, and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the system rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_data | input | 8 | Byte to send for write kinds |
| wr_dly | input | 4 | Write strobe stretch |
| rd_dly | input | 4 | Read strobe stretch |
| rsp_valid | output | 1 | Read byte valid pulse |
| rsp_data | output | 8 | Read byte |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus value driven by the block |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_in | input | 8 | Bus value from the flash |

## Verification
On every cycle, the assertions check the exclusions between pins:
- the two latch enables are never high together;
- the two strobes are never low together;
- no strobe is low while chip enable is high;
- the output enable is never high during a read;
- the response pulse lasts one tick;
- ready is never high while chip enable is active;
- the write-to-read turnaround holds.

The exact tick counts need the bench's scenarios and its tick-by-tick reference model. These counts are the strobe widths for each delay value, the setup and hold spans around the strobes and the tick in which ready returns. The same holds for capturing the right byte and for ignoring delay changes made after acceptance.

// File: rtl/nfs_pkg.sv
`timescale 1ns/1ps
package nfs_pkg;

    typedef enum logic [1:0] {
        KIND_CMD   = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_READ  = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP
    } phase_e;

    // all spans in ticks (half system periods)
    localparam int SETUP_WR_TICKS   = 5;
    localparam int SETUP_RD_TICKS   = 2;
    localparam int HOLD_TICKS       = 6;
    localparam int LATCH_HOLD_TICKS = 5;
    localparam int TURN_TICKS       = 10;

endpackage

// File: rtl/nfs_req_latch.sv
`timescale 1ns/1ps
module nfs_req_latch
    import nfs_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DLYW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  req_kind_e       in_kind,
    input  logic [DW-1:0]   in_data,
    input  logic [DLYW-1:0] in_wr_dly,
    input  logic [DLYW-1:0] in_rd_dly,
    output req_kind_e       cur_kind,
    output logic [DW-1:0]   cur_data,
    output logic [DLYW-1:0] cur_dly
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_kind <= KIND_CMD;
            cur_data <= '0;
            cur_dly  <= '0;
        end else if (accept) begin
            cur_kind <= in_kind;
            cur_data <= in_data;
            // keep only the delay that applies to this request
            cur_dly  <= (in_kind == KIND_READ) ? in_rd_dly : in_wr_dly;
        end
    end

endmodule

// File: rtl/nfs_phase_fsm.sv
`timescale 1ns/1ps
module nfs_phase_fsm
    import nfs_pkg::*;
#(
    parameter int DLYW = 4,
    localparam int CNTW = DLYW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  req_kind_e       in_kind,
    input  req_kind_e       cur_kind,
    input  logic [DLYW-1:0] cur_dly,
    output logic            accept,
    output logic            ready,
    output phase_e          state,
    output logic [CNTW-1:0] cnt
);

    localparam logic [CNTW-1:0] SETUP_WR_LAST = CNTW'(SETUP_WR_TICKS - 1);
    localparam logic [CNTW-1:0] SETUP_RD_LAST = CNTW'(SETUP_RD_TICKS - 1);
    localparam logic [CNTW-1:0] HOLD_LAST     = CNTW'(HOLD_TICKS - 1);

    logic cur_is_read;
    assign cur_is_read = (cur_kind == KIND_READ);

    // state register and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= ST_SETUP;
                        cnt   <= (in_kind == KIND_READ) ? SETUP_RD_LAST : SETUP_WR_LAST;
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_STROBE;
                        cnt   <= {cur_dly, 1'b1};   // 2*(dly+1) ticks
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (cnt == '0) begin
                        state <= ST_HOLD;
                        cnt   <= HOLD_LAST;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        state <= cur_is_read ? ST_IDLE : ST_GAP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // handshake outputs
    always_comb begin
        ready  = (state == ST_IDLE);
        accept = ready && req_valid;
    end

    assert_hold_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STROBE && cnt == '0) |=> (state == ST_HOLD && cnt == HOLD_LAST))
        else $error("strobe end did not start the full hold span");

endmodule

// File: rtl/nfs_pin_drive.sv
`timescale 1ns/1ps
module nfs_pin_drive
    import nfs_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_e          state,
    input  logic [CNTW-1:0] cnt,
    input  req_kind_e       cur_kind,
    input  logic [DW-1:0]   cur_data,
    input  logic [DW-1:0]   dq_in,
    output logic            ce_n,
    output logic            cle,
    output logic            ale,
    output logic            we_n,
    output logic            re_n,
    output logic [DW-1:0]   dq_out,
    output logic            dq_oe,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data
);

    localparam logic [CNTW-1:0] LEAD_MIN = CNTW'(HOLD_TICKS - LATCH_HOLD_TICKS);

    logic is_wr, lead_hold, active, strobe_end;

    // pin decode from phase
    always_comb begin
        is_wr      = (cur_kind != KIND_READ);
        lead_hold  = (state == ST_HOLD) && (cnt >= LEAD_MIN);
        active     = (state == ST_SETUP) || (state == ST_STROBE) || lead_hold;
        strobe_end = (state == ST_STROBE) && (cnt == '0);
        ce_n   = !((state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD));
        we_n   = !((state == ST_STROBE) && is_wr);
        re_n   = !((state == ST_STROBE) && !is_wr);
        cle    = active && (cur_kind == KIND_CMD);
        ale    = active && (cur_kind == KIND_ADDR);
        dq_oe  = active && is_wr;
        dq_out = dq_oe ? cur_data : '0;
    end

    // read capture on the edge that raises the read strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= strobe_end && !is_wr;
            if (strobe_end && !is_wr) begin
                rsp_data <= dq_in;
            end
        end
    end

    // ticks since the write strobe was last low (saturating)
    logic [3:0] since_we;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_we <= 4'hf;
        end else if (!we_n) begin
            since_we <= '0;
        end else if (since_we != 4'hf) begin
            since_we <= since_we + 1'b1;
        end
    end

    assert_one_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)) else $error("both latch enables high");
    assert_strobes_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n)) else $error("both strobes low");
    assert_strobe_needs_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (we_n && re_n)) else $error("strobe low without chip enable");
    assert_oe_not_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (re_n && !ce_n)) else $error("bus driven during read or idle");
    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(re_n) |-> (since_we >= 4'(TURN_TICKS))) else $error("write-to-read gap short");
    assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid) else $error("response valid longer than one tick");

endmodule

// File: rtl/nfs_sequencer.sv
`timescale 1ns/1ps
module nfs_sequencer
    import nfs_pkg::*;
#(
    parameter int DW   = 8,
    parameter int DLYW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic [DW-1:0]   req_data,
    input  logic [DLYW-1:0] wr_dly,
    input  logic [DLYW-1:0] rd_dly,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            nf_ce_n,
    output logic            nf_cle,
    output logic            nf_ale,
    output logic            nf_we_n,
    output logic            nf_re_n,
    output logic [DW-1:0]   nf_dq_out,
    output logic            nf_dq_oe,
    input  logic [DW-1:0]   nf_dq_in
);

    localparam int CNTW = DLYW + 1;

    req_kind_e       in_kind, cur_kind;
    logic [DW-1:0]   cur_data;
    logic [DLYW-1:0] cur_dly;
    logic            accept;
    phase_e          state;
    logic [CNTW-1:0] cnt;

    assign in_kind = req_kind_e'(req_kind);

    nfs_req_latch #(.DW(DW), .DLYW(DLYW)) latch_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .in_kind(in_kind),
        .in_data(req_data), .in_wr_dly(wr_dly), .in_rd_dly(rd_dly),
        .cur_kind(cur_kind), .cur_data(cur_data), .cur_dly(cur_dly)
    );

    nfs_phase_fsm #(.DLYW(DLYW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .in_kind(in_kind),
        .cur_kind(cur_kind), .cur_dly(cur_dly), .accept(accept),
        .ready(req_ready), .state(state), .cnt(cnt)
    );

    nfs_pin_drive #(.DW(DW), .CNTW(CNTW)) pins_i (
        .clk(clk), .rst_n(rst_n), .state(state), .cnt(cnt),
        .cur_kind(cur_kind), .cur_data(cur_data), .dq_in(nf_dq_in),
        .ce_n(nf_ce_n), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n),
        .re_n(nf_re_n), .dq_out(nf_dq_out), .dq_oe(nf_dq_oe),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> nf_ce_n) else $error("ready while chip enable active");

endmodule

// File: tb/nfs_sequencer_tb_top.sv
`timescale 1ns/1ps
module nfs_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'd0;
    logic [7:0] req_data = 8'h00;
    logic [3:0] wr_dly = 4'd0;
    logic [3:0] rd_dly = 4'd0;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0] nf_dq_out;
    logic [7:0] nf_dq_in = 8'h00;

    always #4 clk = ~clk;   // 125 MHz

    nfs_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_data(req_data), .wr_dly(wr_dly), .rd_dly(rd_dly),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .nf_ce_n(nf_ce_n),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in)
    );

    typedef struct packed {
        logic       ce_n, cle, ale, we_n, re_n, oe, ready, rv;
        logic [7:0] dq, rd;
    } exp_t;

    exp_t  expq[$];
    int    checks = 0;
    int    errors = 0;
    bit    run_mon = 0;
    bit    done = 0;
    string scen = "R11";

    bit       pend = 0;
    int       p_kind, p_wd, p_rd;
    logic [7:0] p_data, p_din;

    function automatic exp_t idle_exp();
        exp_t e;
        e = '{ce_n:1, cle:0, ale:0, we_n:1, re_n:1, oe:0, ready:1, rv:0, dq:8'h00, rd:8'h00};
        return e;
    endfunction

    // reference waveform for one accepted request, tick 0 = first tick after accept
    task automatic build(input int kind, input logic [7:0] data, input int wd,
                         input int rd, input logic [7:0] din);
        int s, l, tot;
        bit wr;
        wr  = (kind != 3);
        s   = wr ? 5 : 2;
        l   = wr ? 2 * (wd + 1) : 2 * (rd + 1);
        tot = s + l + 6 + (wr ? 1 : 0);
        for (int t = 0; t < tot; t++) begin
            exp_t e;
            bit act;
            e = idle_exp();
            e.ready = 0;
            act = (t < s + l + 5);
            if (t < s + l + 6) e.ce_n = 0;
            if (t >= s && t < s + l) begin
                if (wr) e.we_n = 0; else e.re_n = 0;
            end
            if (act && kind == 0) e.cle = 1;
            if (act && kind == 1) e.ale = 1;
            if (act && wr) begin e.oe = 1; e.dq = data; end
            if (!wr && t == s + l) begin e.rv = 1; e.rd = din; end
            expq.push_back(e);
        end
    endtask

    task automatic chk(input string what, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] %s: actual %h expected %h at %0t",
                     tag, scen, what, act, exp, $time);
        end
    endtask

    int cyc = 0;
    int last_we_low = -1000;
    bit prev_re_n = 1;

    always @(negedge clk) begin
        cyc++;
        if (run_mon && !done) begin
            exp_t e;
            if (pend) begin
                build(p_kind, p_data, p_wd, p_rd, p_din);
                pend = 0;
            end
            e = (expq.size() > 0) ? expq.pop_front() : idle_exp();
            checks++;
            chk("ce_n",  "R4",  {7'd0, nf_ce_n},   {7'd0, e.ce_n});
            chk("cle",   "R1/R5", {7'd0, nf_cle},  {7'd0, e.cle});
            chk("ale",   "R1/R5", {7'd0, nf_ale},  {7'd0, e.ale});
            chk("we_n",  "R2",  {7'd0, nf_we_n},   {7'd0, e.we_n});
            chk("re_n",  "R3",  {7'd0, nf_re_n},   {7'd0, e.re_n});
            chk("dq_oe", "R6",  {7'd0, nf_dq_oe},  {7'd0, e.oe});
            if (e.oe) chk("dq_out", "R6", nf_dq_out, e.dq);
            chk("ready", "R10", {7'd0, req_ready}, {7'd0, e.ready});
            chk("rsp_valid", "R8", {7'd0, rsp_valid}, {7'd0, e.rv});
            if (e.rv) chk("rsp_data", "R8", rsp_data, e.rd);
            // R7: write strobe rise to read strobe fall
            if (prev_re_n && !nf_re_n && last_we_low > 0) begin
                checks++;
                if (cyc - last_we_low - 1 < 10) begin
                    errors++;
                    $display("FAIL R7 turnaround: actual %0d expected >= 10",
                             cyc - last_we_low - 1);
                end
            end
            if (!nf_we_n) last_we_low = cyc;
            prev_re_n = nf_re_n;
            if (req_valid && req_ready) begin
                pend   = 1;
                p_kind = int'(req_kind);
                p_data = req_data;
                p_wd   = int'(wr_dly);
                p_rd   = int'(rd_dly);
                p_din  = nf_dq_in;
            end
        end
    end

    // one request; fields are scrambled after acceptance (R9)
    task automatic send(input logic [1:0] kind, input logic [7:0] data,
                        input logic [3:0] wd, input logic [3:0] rd,
                        input logic [7:0] din, input string tag);
        while (!req_ready) begin
            @(posedge clk); #1;
        end
        scen      = tag;
        req_valid = 1'b1;
        req_kind  = kind;
        req_data  = data;
        wr_dly    = wd;
        rd_dly    = rd;
        nf_dq_in  = din;
        @(posedge clk); #1;
        req_valid = 1'b0;
        req_kind  = ~kind;
        req_data  = ~data;
        wr_dly    = wd ^ 4'hb;
        rd_dly    = rd ^ 4'h6;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: values held in reset
        checks++;
        if ({nf_ce_n, nf_we_n, nf_re_n, req_ready} !== 4'hf ||
            {nf_cle, nf_ale, nf_dq_oe, rsp_valid} !== 4'h0) begin
            errors++;
            $display("FAIL R11 reset pins: actual %b expected 11110000",
                     {nf_ce_n, nf_we_n, nf_re_n, req_ready, nf_cle, nf_ale, nf_dq_oe, rsp_valid});
        end
        @(posedge clk); #1;
        rst_n   = 1'b1;
        run_mon = 1;
        repeat (3) @(posedge clk); #1;
        send(2'd0, 8'h70, 4'd0, 4'd0, 8'h00, "R1 cmd");
        send(2'd1, 8'h3c, 4'd3, 4'd0, 8'h00, "R5 addr");
        send(2'd2, 8'ha5, 4'd15, 4'd0, 8'h00, "R2 write max");
        send(2'd3, 8'h00, 4'd0, 4'd0, 8'h5a, "R7 read after write");
        send(2'd3, 8'h00, 4'd7, 4'd0, 8'hc3, "R3 read stretched");
        repeat (5) @(posedge clk); #1;
        send(2'd3, 8'h00, 4'd0, 4'd15, 8'h81, "R3 read max");
        send(2'd2, 8'h11, 4'd2, 4'd9, 8'h00, "R9 write");
        send(2'd3, 8'h00, 4'd12, 4'd1, 8'h24, "R9 read");
        send(2'd0, 8'hff, 4'd1, 4'd0, 8'h00, "R10 cmd pair");
        send(2'd0, 8'h00, 4'd1, 4'd0, 8'h00, "R10 cmd pair");
        send(2'd2, 8'h96, 4'd0, 4'd0, 8'h00, "R6 write min");
        send(2'd3, 8'h00, 4'd3, 4'd3, 8'he7, "R8 read");
        send(2'd1, 8'h42, 4'd5, 4'd0, 8'h00, "R1 addr");
        repeat (60) @(posedge clk); #1;
        done = 1;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R10 leftover expected ticks: actual %0d expected 0", expq.size());
        end
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        done = 1;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule